// File: doc/BRIEF.md
# Power-On Self-Test and Configuration Sequencer

This block brings a supply-monitor chip from power-up to normal operation. Once the supply-good input goes high it arms a sequence timeout counter. If a strap input asks for it, it runs a self test through a request/done handshake. It then reads a fixed number of configuration words from a one-time-programmable store. Each word passes through a single-error-correct, double-error-detect decoder, and the result is kept in an output register bank.

The host register port and the active-low interrupt pin stay disabled until the sequence is complete. After that the host can see the self-test result and the ECC result in a test-information register, poll a status register, and handle sticky interrupt flags. A flag is cleared by writing 1 to it. A drop of the supply-good input sends the block back to idle from any state and clears everything it has loaded or recorded.

The store is read over a request channel with valid/ready. The sequencer raises `otp_req_valid` with `otp_req_addr`, and holds both unchanged until a cycle in which `otp_req_ready` is high; that cycle transfers the request. Only one request is outstanding at a time. The response channel has no ready signal: the sequencer always accepts `otp_rsp_valid` while a request is outstanding.

Top module: `pwrup_seq_ctrl`

## Requirements
- R1: After reset, and while `uvlo_ok` is low, the outputs are `host_en`=0, `irq_n`=1, `bist_req`=0 and `otp_req_valid`=0, and `reg_rdata` reads 0.
- R2: When `uvlo_ok` rises with `cfg_bist_at_por`=1, `bist_req` goes high and stays high until the cycle after `bist_done` is seen. With `cfg_bist_at_por`=0, `bist_req` never rises and loading starts at once.
- R3: Configuration words are requested at addresses 0 to N_WORDS-1 in ascending order, one outstanding at a time. A request with no ready keeps its valid and address stable.
- R4: The codeword encoding is as follows. Bit 0 is even parity over the whole word. Check bits sit at the power-of-two positions. Data bits fill the remaining positions in ascending order, LSB first. A clean word appears unchanged in its slot of `cfg_words` (word i at bits i*DATA_W and up).
- R5: A single flipped codeword bit is corrected, and TEST_INFO (address 1) bit 2 becomes 1.
- R6: Two flipped bits leave the slot holding DFLT_WORD, and TEST_INFO bit 3 becomes 1.
- R7: `host_en` rises in the cycle after the last configuration response is accepted. Before that, register writes are ignored and reads return 0.
- R8: TEST_INFO bit 0 shows that the self test completed and bit 1 shows that it passed. STATUS (address 0) bit 0 shows that the self test completed and bit 1 shows that the host is enabled.
- R9: INT_FLAG (address 2) bit 0 is set when the self test completes. INT_EN is at address 3. `irq_n` is low exactly when the host is enabled and some flag has its enable set.
- R10: A write to INT_FLAG clears each flag written with 1. A flag written with 0 keeps its value.
- R11: INT_FLAG bit 1 is set if the sequence stays in self test or loading for TMO_CYCLES cycles. A faster sequence never sets it.
- R12: A low `uvlo_ok` returns the block to idle. It zeroes `cfg_words`, the test information, the status, the flags and the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uvlo_ok | input | 1 | Supply above the lockout threshold |
| cfg_bist_at_por | input | 1 | Run the self test during power-up |
| bist_req | output | 1 | Self test requested |
| bist_done | input | 1 | Self test finished (one-cycle pulse) |
| bist_pass | input | 1 | Self test result, valid with done |
| otp_req_valid | output | 1 | Read request valid |
| otp_req_ready | input | 1 | Store accepts the request |
| otp_req_addr | output | AW | Word address |
| otp_rsp_valid | input | 1 | Response codeword valid |
| otp_rsp_code | input | CW | Response codeword |
| host_en | output | 1 | Host interface and fault path enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cfg_words | output | N_WORDS*DATA_W | Loaded configuration |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The loading path is exercised with three kinds of codeword: clean, one flipped bit, and two flipped bits. Together they separate the pass-through, correction and default-substitution branches of the decoder, along with their test-information bits. Power-up runs once with the self test enabled and a short wait, once with it skipped, and once with a wait longer than the timeout. These runs separate the self-test gating from the timeout flag. A stalled ready on one request shows that addresses keep their order under back-pressure. Writes made before and after enabling, with both 0 and 1 data, show the gating and the write-1-to-clear rule.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BIST   = 2'd1,
    ST_LOAD   = 2'd2,
    ST_ACTIVE = 2'd3
  } seq_state_e;

  localparam int REG_W = 8;
  localparam logic [1:0] RA_STATUS = 2'd0;
  localparam logic [1:0] RA_TINFO  = 2'd1;
  localparam logic [1:0] RA_FLAG   = 2'd2;
  localparam logic [1:0] RA_EN     = 2'd3;

  // number of Hamming check bits for a given data width
  function automatic int ecc_par_bits(int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // codeword position of data bit j (non-power-of-two positions, ascending)
  function automatic int ecc_data_pos(int j);
    int r;
    int cnt;
    r = 0;
    cnt = 0;
    for (int pos = 1; pos < 128; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (cnt == j) r = pos;
        cnt++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/secded_dec.sv
module secded_dec import pwrup_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int P  = ecc_par_bits(DATA_W),
  localparam int CW = DATA_W + P + 1
) (
  input  logic [CW-1:0]     code,
  output logic [DATA_W-1:0] data,
  output logic              corrected,
  output logic              uncorrectable
);

  logic [P-1:0]  syn;
  logic          par;
  logic [CW-1:0] fixed;

  always_comb begin
    syn = '0;
    par = ^code;
    for (int i = 1; i < CW; i++) begin
      if (code[i]) syn = syn ^ P'(i);
    end
    fixed = code;
    if (par && (int'(syn) < CW)) fixed[syn] = ~code[syn];
  end

  for (genvar j = 0; j < DATA_W; j++) begin : g_extract
    assign data[j] = fixed[ecc_data_pos(j)];
  end

  assign corrected     = par;
  assign uncorrectable = !par && (syn != '0);

endmodule

// File: rtl/seq_tmo_timer.sv
module seq_tmo_timer #(
  parameter int TMR_W      = 12,
  parameter int TMO_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);

  localparam logic [TMR_W-1:0] LOAD_VAL = TMR_W'(TMO_CYCLES - 1);

  logic [TMR_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (start) begin
      cnt   <= LOAD_VAL;
      armed <= 1'b1;
    end else if (armed && run) begin
      if (cnt == '0) armed <= 1'b0;
      else           cnt   <= cnt - 1'b1;
    end
  end

  assign expire = armed && run && (cnt == '0);

endmodule

// File: rtl/pwrup_regs.sv
module pwrup_regs import pwrup_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic             bist_evt,
  input  logic             bist_ok,
  input  logic             corr_evt,
  input  logic             unc_evt,
  input  logic             tmo_evt,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq_n
);

  logic       st_bist;
  logic       ti_ran, ti_pass, ti_corr, ti_unc;
  logic [1:0] flags, en;
  logic       wr_ok;
  logic [1:0] w1c;
  logic       unused_wbits;

  assign wr_ok        = wr && active;
  assign w1c          = (wr_ok && addr == RA_FLAG) ? wdata[1:0] : 2'b00;
  assign unused_wbits = ^wdata[REG_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_bist <= 1'b0;
      ti_ran  <= 1'b0;
      ti_pass <= 1'b0;
      ti_corr <= 1'b0;
      ti_unc  <= 1'b0;
      flags   <= 2'b00;
      en      <= 2'b00;
    end else if (clr) begin
      st_bist <= 1'b0;
      ti_ran  <= 1'b0;
      ti_pass <= 1'b0;
      ti_corr <= 1'b0;
      ti_unc  <= 1'b0;
      flags   <= 2'b00;
      en      <= 2'b00;
    end else begin
      if (bist_evt) begin
        st_bist <= 1'b1;
        ti_ran  <= 1'b1;
        ti_pass <= bist_ok;
      end
      if (corr_evt) ti_corr <= 1'b1;
      if (unc_evt)  ti_unc  <= 1'b1;
      flags <= (flags & ~w1c) | {tmo_evt, bist_evt};
      if (wr_ok && addr == RA_EN) en <= wdata[1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (active) begin
      unique case (addr)
        RA_STATUS: rdata[1:0] = {active, st_bist};
        RA_TINFO:  rdata[3:0] = {ti_unc, ti_corr, ti_pass, ti_ran};
        RA_FLAG:   rdata[1:0] = flags;
        default:   rdata[1:0] = en;
      endcase
    end
  end

  assign irq_n = !(active && |(flags & en));

endmodule

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl import pwrup_pkg::*; #(
  parameter int          DATA_W     = 8,
  parameter int          N_WORDS    = 4,
  parameter int          TMR_W      = 12,
  parameter int          TMO_CYCLES = 200,
  parameter logic [DATA_W-1:0] DFLT_WORD = 'hA5,
  localparam int P  = ecc_par_bits(DATA_W),
  localparam int CW = DATA_W + P + 1,
  localparam int AW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      uvlo_ok,
  input  logic                      cfg_bist_at_por,
  output logic                      bist_req,
  input  logic                      bist_done,
  input  logic                      bist_pass,
  output logic                      otp_req_valid,
  input  logic                      otp_req_ready,
  output logic [AW-1:0]             otp_req_addr,
  input  logic                      otp_rsp_valid,
  input  logic [CW-1:0]             otp_rsp_code,
  output logic                      host_en,
  input  logic                      reg_wr,
  input  logic [1:0]                reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  output logic [N_WORDS*DATA_W-1:0] cfg_words,
  output logic                      irq_n
);

  localparam logic [AW-1:0] LAST_IDX = AW'(N_WORDS - 1);

  seq_state_e        st;
  logic [AW-1:0]     idx;
  logic              pend;
  logic [DATA_W-1:0] cfg_q [N_WORDS];

  logic [DATA_W-1:0] dec_data, word_in;
  logic              dec_corr, dec_unc;
  logic              take_rsp, bist_evt, tmo_evt;
  logic              tmr_start, tmr_run;

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .code          (otp_rsp_code),
    .data          (dec_data),
    .corrected     (dec_corr),
    .uncorrectable (dec_unc)
  );

  assign word_in  = dec_unc ? DFLT_WORD : dec_data;
  assign take_rsp = (st == ST_LOAD) && pend && otp_rsp_valid;
  assign bist_evt = (st == ST_BIST) && bist_done && uvlo_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      pend  <= 1'b0;
      cfg_q <= '{default: '0};
    end else if (!uvlo_ok) begin
      st    <= ST_IDLE;
      idx   <= '0;
      pend  <= 1'b0;
      cfg_q <= '{default: '0};
    end else begin
      unique case (st)
        ST_IDLE: begin
          idx  <= '0;
          pend <= 1'b0;
          st   <= cfg_bist_at_por ? ST_BIST : ST_LOAD;
        end
        ST_BIST: begin
          if (bist_done) st <= ST_LOAD;
        end
        ST_LOAD: begin
          if (!pend && otp_req_ready) pend <= 1'b1;
          if (take_rsp) begin
            pend       <= 1'b0;
            cfg_q[idx] <= word_in;
            if (idx == LAST_IDX) st  <= ST_ACTIVE;
            else                 idx <= idx + 1'b1;
          end
        end
        default: st <= ST_ACTIVE;
      endcase
    end
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_cfg
    assign cfg_words[w*DATA_W +: DATA_W] = cfg_q[w];
  end

  assign bist_req      = (st == ST_BIST);
  assign otp_req_valid = (st == ST_LOAD) && !pend;
  assign otp_req_addr  = idx;
  assign host_en       = (st == ST_ACTIVE);

  assign tmr_start = (st == ST_IDLE) && uvlo_ok;
  assign tmr_run   = ((st == ST_BIST) || (st == ST_LOAD)) && uvlo_ok;

  seq_tmo_timer #(.TMR_W(TMR_W), .TMO_CYCLES(TMO_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .run    (tmr_run),
    .expire (tmo_evt)
  );

  pwrup_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!uvlo_ok),
    .active   (host_en),
    .bist_evt (bist_evt),
    .bist_ok  (bist_pass),
    .corr_evt (take_rsp && dec_corr),
    .unc_evt  (take_rsp && dec_unc),
    .tmo_evt  (tmo_evt),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .irq_n    (irq_n)
  );

endmodule

// File: rtl/pwrup_seq_sva.sv
module pwrup_seq_sva #(
  parameter int AW      = 2,
  parameter int N_WORDS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uvlo_ok,
  input logic          bist_req,
  input logic          bist_done,
  input logic          otp_req_valid,
  input logic          otp_req_ready,
  input logic [AW-1:0] otp_req_addr,
  input logic          otp_rsp_valid,
  input logic          host_en,
  input logic          irq_n,
  input logic [7:0]    reg_rdata
);

  localparam logic [AW-1:0] LAST_IDX = AW'(N_WORDS - 1);

  AST_QUIET_BELOW_UVLO: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (!host_en && !bist_req && !otp_req_valid)); // R12

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |-> irq_n); // R9

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |-> (reg_rdata == 8'h00)); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_req_valid && !otp_req_ready && uvlo_ok) |=> (otp_req_valid && $stable(otp_req_addr))); // R3

  AST_ENABLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_en) |-> $past(otp_rsp_valid && otp_req_addr == LAST_IDX)); // R7

  AST_BIST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_req && bist_done && uvlo_ok) |=> !bist_req); // R2

endmodule

bind pwrup_seq_ctrl pwrup_seq_sva #(.AW(AW), .N_WORDS(N_WORDS)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .uvlo_ok       (uvlo_ok),
  .bist_req      (bist_req),
  .bist_done     (bist_done),
  .otp_req_valid (otp_req_valid),
  .otp_req_ready (otp_req_ready),
  .otp_req_addr  (otp_req_addr),
  .otp_rsp_valid (otp_rsp_valid),
  .host_en       (host_en),
  .irq_n         (irq_n),
  .reg_rdata     (reg_rdata)
);

// File: tb/tb_pwrup_seq_ctrl.sv
module tb_pwrup_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int CWB = 13;

  logic clk = 1'b0, rst_n = 1'b0, uvlo = 1'b0, cfg_bist = 1'b0;
  logic bist_req, bist_done = 1'b0, bist_pass = 1'b0;
  logic otp_req_valid, otp_req_ready = 1'b1;
  logic [1:0] otp_req_addr;
  logic otp_rsp_valid = 1'b0;
  logic [CWB-1:0] otp_rsp_code = '0;
  logic host_en, irq_n;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic [NW*8-1:0] cfg_words;

  int total = 0, bad = 0, cyc = 0;
  logic [CWB-1:0] mem [NW];
  logic pend = 1'b0;
  logic [1:0] pend_addr = 2'd0;
  int stall_left = 0, log_n = 0, rsp_last = -1;
  logic [1:0] addr_log [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo), .cfg_bist_at_por(cfg_bist),
    .bist_req(bist_req), .bist_done(bist_done), .bist_pass(bist_pass),
    .otp_req_valid(otp_req_valid), .otp_req_ready(otp_req_ready),
    .otp_req_addr(otp_req_addr), .otp_rsp_valid(otp_rsp_valid),
    .otp_rsp_code(otp_rsp_code), .host_en(host_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_words(cfg_words), .irq_n(irq_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // store model: one stalled request at address 1, response one cycle after transfer
  always @(negedge clk) begin
    otp_rsp_valid = 1'b0;
    if (!uvlo) begin
      pend = 1'b0;
      otp_req_ready = 1'b1;
    end else begin
      if (pend) begin
        otp_rsp_valid = 1'b1;
        otp_rsp_code = mem[pend_addr];
        pend = 1'b0;
        if (pend_addr == 2'd3) rsp_last = cyc;
      end
      otp_req_ready = 1'b1;
      if (otp_req_valid && otp_req_addr == 2'd1 && stall_left > 0) begin
        otp_req_ready = 1'b0;
        stall_left--;
      end
      if (otp_req_valid && otp_req_ready) begin
        pend = 1'b1;
        pend_addr = otp_req_addr;
        if (log_n < 8) addr_log[log_n] = otp_req_addr;
        log_n++;
      end
    end
  end

  function automatic logic [CWB-1:0] enc(input logic [7:0] d);
    logic [CWB-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int pos = 1; pos < CWB; pos++)
      if ((pos & (pos - 1)) != 0) begin c[pos] = d[k]; k++; end
    for (int b = 0; b < 4; b++)
      for (int pos = 1; pos < CWB; pos++)
        if (pos[b] && pos != (1 << b)) c[1 << b] ^= c[pos];
    c[0] = ^c[CWB-1:1];
    return c;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic power_up(input logic bist_on, input int bist_wait, input logic pass_v);
    int n;
    logic [7:0] v;
    cfg_bist = bist_on; log_n = 0; rsp_last = -1; stall_left = 3;
    uvlo = 1'b1;
    if (bist_on) begin
      n = 0;
      while (!bist_req && n < 20) begin @(negedge clk); n++; end
      chk("R2 bist_req raised", bist_req, 1'b1);
      wr(2'd3, 8'h03);
      rd(2'd3, v);
      chk("R7 read before enable", v, 8'h00);
      repeat (bist_wait) @(negedge clk);
      chk("R2 bist_req held", bist_req, 1'b1);
      bist_done = 1'b1; bist_pass = pass_v;
      @(negedge clk);
      bist_done = 1'b0;
      chk("R2 bist_req released", bist_req, 1'b0);
    end
    n = 0;
    while (!host_en && n < 1000) begin @(negedge clk); n++; end
    chk("R7 host_en timing", cyc, rsp_last + 1);
  endtask

  task automatic t_reset();
    chk("R1 host_en", host_en, 1'b0);
    chk("R1 irq_n", irq_n, 1'b1);
    chk("R1 bist_req", bist_req, 1'b0);
    chk("R1 otp_req_valid", otp_req_valid, 1'b0);
    chk("R1 rdata", reg_rdata, 8'h00);
  endtask

  task automatic t_bist_clean();
    logic [7:0] v;
    for (int i = 0; i < NW; i++) mem[i] = enc(8'h11 * (i + 3));
    power_up(1'b1, 6, 1'b1);
    chk("R3 request count", log_n, NW);
    for (int i = 0; i < NW; i++) chk("R3 request order", addr_log[i], i);
    for (int i = 0; i < NW; i++) chk("R4 clean word", cfg_words[i*8 +: 8], 8'h11 * (i + 3));
    rd(2'd1, v); chk("R8 test info pass", v, 8'h03);
    rd(2'd0, v); chk("R8 status", v, 8'h03);
    rd(2'd3, v); chk("R7 early write ignored", v, 8'h00);
    rd(2'd2, v); chk("R11 no timeout, R9 bist flag", v, 8'h01);
    chk("R9 irq masked", irq_n, 1'b1);
    wr(2'd3, 8'h01);
    chk("R9 irq asserted", irq_n, 1'b0);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R10 write zero keeps flag", v, 8'h01);
    chk("R10 irq still low", irq_n, 1'b0);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R10 write one clears", v, 8'h00);
    chk("R10 irq released", irq_n, 1'b1);
  endtask

  task automatic t_drop();
    uvlo = 1'b0;
    @(negedge clk);
    chk("R12 cfg cleared", cfg_words, '0);
    chk("R12 host_en low", host_en, 1'b0);
    chk("R12 irq_n high", irq_n, 1'b1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_skip_ecc();
    logic [7:0] v;
    int seen;
    mem[0] = enc(8'h5C);
    mem[1] = enc(8'h3B) ^ 13'h0040;
    mem[2] = enc(8'hE7) ^ 13'h0028;
    mem[3] = enc(8'h01);
    seen = 0;
    fork
      begin power_up(1'b0, 0, 1'b0); end
      begin repeat (30) begin @(negedge clk); if (bist_req) seen++; end end
    join
    chk("R2 no bist when strap low", seen, 0);
    chk("R4 word0", cfg_words[7:0], 8'h5C);
    chk("R5 single error corrected", cfg_words[15:8], 8'h3B);
    chk("R6 double error default", cfg_words[23:16], 8'hA5);
    chk("R4 word3", cfg_words[31:24], 8'h01);
    rd(2'd1, v); chk("R5 R6 R12 test info", v, 8'h0C);
    rd(2'd0, v); chk("R8 status no bist", v, 8'h02);
    rd(2'd2, v); chk("R12 flags cleared", v, 8'h00);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    for (int i = 0; i < NW; i++) mem[i] = enc(8'h20 + i);
    power_up(1'b1, 250, 1'b0);
    rd(2'd2, v); chk("R11 timeout flag", v, 8'h03);
    rd(2'd1, v); chk("R8 test info fail", v, 8'h01);
    wr(2'd3, 8'h02);
    chk("R9 irq on timeout", irq_n, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_bist_clean();
    t_drop();
    t_skip_ecc();
    t_drop();
    t_timeout();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule